// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. It is purely combinational. It takes a 4-bit operation select, a register operand `a_i`, a memory operand `m_i` and the current status byte. It returns a result byte and the next status byte. The surrounding datapath handles instruction decode, operand fetch and writeback. It decides whether the result is written anywhere and always takes the returned status byte as the new flags.

Each operation rewrites only its own group of flags. Every other status bit comes back exactly as it went in. This includes the interrupt-disable, decimal, break and spare bit 5. Arithmetic is always binary. Subtraction and compare reuse the adder by feeding it the inverted operand. The bit-test operation copies the top two operand bits straight into the flags.

Status layout, which the datapath decodes: carry bit 0, zero bit 1, interrupt-disable bit 2, decimal bit 3, break bit 4, overflow bit 6, negative bit 7. In every requirement below, Z is set exactly when the named value is zero, and N is bit 7 of that value.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) returns A+M+C modulo 256. C is set when the 9-bit sum exceeds 0xFF. V is set when A and M share a sign bit and the result's sign differs from A. Z and N come from the result.
- R2: Subtract (op 1) returns A+(0xFF−M)+C modulo 256. C set means no borrow. V is set when A and M differ in sign and the result's sign differs from A. Z and N come from the result.
- R3: Compare (op 2) returns A unchanged. It sets C when A ≥ M (unsigned) and takes Z and N from (A−M) mod 256. V is left as it was.
- R4: AND (op 3), OR (op 4) and XOR (op 5) return A combined bitwise with M. They update only Z and N.
- R5: Bit-test (op 6) returns A unchanged. It sets Z when (A AND M) is zero, copies M bit 7 into N and M bit 6 into V, and leaves C as it was.
- R6: Increment (op 7) and decrement (op 8) act on A with wraparound at 8 bits. They update only Z and N.
- R7: Shift left (op 9) and rotate left (op 11) move A bit 7 into C. Shift left fills bit 0 with 0; rotate left fills it with the incoming C. Z and N come from the result.
- R8: Shift right (op 10) and rotate right (op 12) move A bit 0 into C. Shift right fills bit 7 with 0; rotate right fills it with the incoming C. Z and N come from the result.
- R9: Move (op 13) returns M and updates only Z and N.
- R10: For every op, status bits 2, 3, 4 and 5 come out equal to their inputs. The decimal bit never changes any result or arithmetic flag.
- R11: For undefined ops 14 and 15, the result is A and the status byte is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select, encoding as in the requirements |
| a_i | input | 8 | Register operand (accumulator or index) |
| m_i | input | 8 | Memory or immediate operand |
| status_i | input | 8 | Incoming status byte |
| result_o | output | 8 | Operation result |
| status_o | output | 8 | Updated status byte |

## Verification
The add and subtract paths are driven with operands that straddle the sign boundary (0x50 and 0xB0 pairings) to separate overflow from carry. Wrap cases such as 0xFF+1 and 0−1 check carry and borrow polarity with a zero result. Compare is tried with equal, smaller and larger operands while V is preset, to show that V is left alone. The shifts and rotates are run with both incoming carry values and with the end bits set, which separates the shifts from the rotates. Every op, including the two undefined codes, then gets a long run of pseudo-random operands and status bytes with the decimal bit toggling, compared against a behavioural model of the flag rules.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int STATUS_W = 8;
    localparam int FLG_C    = 0;
    localparam int FLG_Z    = 1;
    localparam int FLG_V    = 6;
    localparam int FLG_N    = 7;

    typedef enum logic [3:0] {
        OP_ADD_C = 4'd0,
        OP_SUB_B = 4'd1,
        OP_CMP   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_TEST  = 4'd6,
        OP_INC   = 4'd7,
        OP_DEC   = 4'd8,
        OP_SHL   = 4'd9,
        OP_SHR   = 4'd10,
        OP_ROTL  = 4'd11,
        OP_ROTR  = 4'd12,
        OP_MOVE  = 4'd13
    } alu_op_e;

    // One bit per arithmetic flag; used both for new values and update masks
    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] m_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output flags_t           flags_o,
    output flags_t           upd_o
);
    localparam int MSB = WIDTH - 1;

    logic             sub_mode_d;
    logic             is_cmp_d;
    logic             cin_d;
    logic [WIDTH-1:0] opnd_d;
    logic [WIDTH:0]   sum_d;
    logic             ovf_d;

    always_comb begin
        is_cmp_d   = (op_i == OP_CMP);
        sub_mode_d = (op_i == OP_SUB_B) || is_cmp_d;
        // compare always behaves as a borrow-free subtract
        cin_d      = is_cmp_d ? 1'b1 : carry_i;
        opnd_d     = sub_mode_d ? ~m_i : m_i;
        sum_d      = {1'b0, a_i} + {1'b0, opnd_d} + {{WIDTH{1'b0}}, cin_d};
        // same sign going in, different sign coming out
        ovf_d      = ~(a_i[MSB] ^ opnd_d[MSB]) & (a_i[MSB] ^ sum_d[MSB]);

        res_o      = is_cmp_d ? a_i : sum_d[WIDTH-1:0];

        flags_o.c  = sum_d[WIDTH];
        flags_o.z  = (sum_d[WIDTH-1:0] == '0);
        flags_o.n  = sum_d[MSB];
        flags_o.v  = ovf_d;

        upd_o.c    = 1'b1;
        upd_o.z    = 1'b1;
        upd_o.n    = 1'b1;
        upd_o.v    = ~is_cmp_d;
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] m_i,
    output logic [WIDTH-1:0] res_o,
    output flags_t           flags_o,
    output flags_t           upd_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] masked_d;
    logic [WIDTH-1:0] zn_src_d;
    logic             is_test_d;

    always_comb begin
        masked_d  = a_i & m_i;
        is_test_d = (op_i == OP_TEST);

        unique case (op_i)
            OP_AND:  res_o = masked_d;
            OP_OR:   res_o = a_i | m_i;
            OP_XOR:  res_o = a_i ^ m_i;
            OP_MOVE: res_o = m_i;
            default: res_o = a_i;
        endcase

        zn_src_d  = is_test_d ? masked_d : res_o;

        flags_o.c = 1'b0;
        flags_o.z = (zn_src_d == '0);
        // bit-test takes the sign flags from the operand itself
        flags_o.n = is_test_d ? m_i[MSB] : res_o[MSB];
        flags_o.v = m_i[MSB-1];

        upd_o.c   = 1'b0;
        upd_o.z   = 1'b1;
        upd_o.n   = 1'b1;
        upd_o.v   = is_test_d;
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output flags_t           flags_o,
    output flags_t           upd_o
);
    localparam int MSB = WIDTH - 1;

    logic left_fill_d;
    logic right_fill_d;
    logic shifting_d;

    always_comb begin
        left_fill_d  = (op_i == OP_ROTL) ? carry_i : 1'b0;
        right_fill_d = (op_i == OP_ROTR) ? carry_i : 1'b0;
        shifting_d   = (op_i == OP_SHL) || (op_i == OP_SHR) ||
                       (op_i == OP_ROTL) || (op_i == OP_ROTR);

        unique case (op_i)
            OP_INC:           res_o = a_i + {{(WIDTH-1){1'b0}}, 1'b1};
            OP_DEC:           res_o = a_i - {{(WIDTH-1){1'b0}}, 1'b1};
            OP_SHL, OP_ROTL:  res_o = {a_i[MSB-1:0], left_fill_d};
            OP_SHR, OP_ROTR:  res_o = {right_fill_d, a_i[MSB:1]};
            default:          res_o = a_i;
        endcase

        flags_o.c = ((op_i == OP_SHL) || (op_i == OP_ROTL)) ? a_i[MSB] : a_i[0];
        flags_o.z = (res_o == '0);
        flags_o.n = res_o[MSB];
        flags_o.v = 1'b0;

        upd_o.c   = shifting_d;
        upd_o.z   = 1'b1;
        upd_o.n   = 1'b1;
        upd_o.v   = 1'b0;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]          op_i,
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    m_i,
    input  logic [STATUS_W-1:0] status_i,
    output logic [WIDTH-1:0]    result_o,
    output logic [STATUS_W-1:0] status_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        flags_t           flags;
        flags_t           upd;
    } unit_out_t;

    unit_out_t arith_d;
    unit_out_t logic_d;
    unit_out_t shift_d;
    unit_out_t pick_d;

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op_i    (op_i),
        .a_i     (a_i),
        .m_i     (m_i),
        .carry_i (status_i[FLG_C]),
        .res_o   (arith_d.res),
        .flags_o (arith_d.flags),
        .upd_o   (arith_d.upd)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .op_i    (op_i),
        .a_i     (a_i),
        .m_i     (m_i),
        .res_o   (logic_d.res),
        .flags_o (logic_d.flags),
        .upd_o   (logic_d.upd)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .op_i    (op_i),
        .a_i     (a_i),
        .carry_i (status_i[FLG_C]),
        .res_o   (shift_d.res),
        .flags_o (shift_d.flags),
        .upd_o   (shift_d.upd)
    );

    always_comb begin
        unique case (op_i)
            OP_ADD_C, OP_SUB_B, OP_CMP:
                pick_d = arith_d;
            OP_AND, OP_OR, OP_XOR, OP_TEST, OP_MOVE:
                pick_d = logic_d;
            OP_INC, OP_DEC, OP_SHL, OP_SHR, OP_ROTL, OP_ROTR:
                pick_d = shift_d;
            default: begin
                pick_d.res   = a_i;
                pick_d.flags = '0;
                pick_d.upd   = '0;
            end
        endcase

        result_o = pick_d.res;
        // only the flags the selected op owns are replaced
        status_o = status_i;
        if (pick_d.upd.c) status_o[FLG_C] = pick_d.flags.c;
        if (pick_d.upd.z) status_o[FLG_Z] = pick_d.flags.z;
        if (pick_d.upd.v) status_o[FLG_V] = pick_d.flags.v;
        if (pick_d.upd.n) status_o[FLG_N] = pick_d.flags.n;
    end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [3:0]          op_i,
    input logic [WIDTH-1:0]    a_i,
    input logic [WIDTH-1:0]    m_i,
    input logic [STATUS_W-1:0] status_i,
    input logic [WIDTH-1:0]    result_o,
    input logic [STATUS_W-1:0] status_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, m_i} + {{WIDTH{1'b0}}, status_i[FLG_C]};

        // R10: system bits are never touched
        a_r10_sys_bits: assert (status_o[5:2] == status_i[5:2]);

        // R1: carry and result form the 9-bit sum
        if (op_i == OP_ADD_C)
            a_r1_carry_sum: assert ({status_o[FLG_C], result_o} == wide_sum);

        // R3: compare keeps the register and overflow
        if (op_i == OP_CMP)
            a_r3_cmp_keeps: assert (result_o == a_i && status_o[FLG_V] == status_i[FLG_V]);

        // R4: logic ops leave carry and overflow alone
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
            a_r4_logic_cv: assert (status_o[FLG_C] == status_i[FLG_C] &&
                                   status_o[FLG_V] == status_i[FLG_V]);

        // R5: bit-test mirrors the operand's top bits
        if (op_i == OP_TEST)
            a_r5_test_copy: assert (status_o[FLG_N] == m_i[MSB] &&
                                    status_o[FLG_V] == m_i[MSB-1] && result_o == a_i);

        // R8: a plain right shift clears the top bit
        if (op_i == OP_SHR)
            a_r8_shr_msb: assert (result_o[MSB] == 1'b0 && status_o[FLG_C] == a_i[0]);

        // R11: undefined selects pass everything through
        if (op_i >= 4'd14)
            a_r11_undef_pass: assert (result_o == a_i && status_o == status_i);
    end

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i     (op_i),
    .a_i      (a_i),
    .m_i      (m_i),
    .status_i (status_i),
    .result_o (result_o),
    .status_o (status_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] a, m, st_in;
    logic [7:0] res, st_out;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    alu8_core u_dut (
        .op_i     (op),
        .a_i      (a),
        .m_i      (m),
        .status_i (st_in),
        .result_o (res),
        .status_o (st_out)
    );

    function automatic int put_bit(int s, int pos, bit v);
        return (s & ~(1 << pos)) | (int'(v) << pos);
    endfunction

    function automatic int put_zn(int s, int v);
        int t = put_bit(s, 1, (v & 255) == 0);
        return put_bit(t, 7, (v & 128) != 0);
    endfunction

    // behavioural model of the flag rules: returns {result, status}
    function automatic logic [15:0] model(int op_v, int av, int mv, int sv);
        int r = av;
        int s = sv;
        int c = sv & 1;
        int t;
        case (op_v)
            0: begin t = av + mv + c; r = t & 255;
                s = put_bit(s, 0, t > 255);
                s = put_bit(s, 6, ((~(av ^ mv)) & (av ^ r) & 128) != 0);
                s = put_zn(s, r); end
            1: begin t = av + (255 - mv) + c; r = t & 255;
                s = put_bit(s, 0, t > 255);
                s = put_bit(s, 6, ((av ^ mv) & (av ^ r) & 128) != 0);
                s = put_zn(s, r); end
            2: begin s = put_bit(s, 0, av >= mv); s = put_zn(s, (av - mv) & 255); end
            3: begin r = av & mv; s = put_zn(s, r); end
            4: begin r = av | mv; s = put_zn(s, r); end
            5: begin r = av ^ mv; s = put_zn(s, r); end
            6: begin s = put_bit(s, 1, (av & mv) == 0);
                s = put_bit(s, 7, (mv & 128) != 0);
                s = put_bit(s, 6, (mv & 64) != 0); end
            7: begin r = (av + 1) & 255; s = put_zn(s, r); end
            8: begin r = (av + 255) & 255; s = put_zn(s, r); end
            9, 11: begin r = ((av << 1) & 255) | ((op_v == 11) ? c : 0);
                s = put_bit(s, 0, (av & 128) != 0); s = put_zn(s, r); end
            10, 12: begin r = (av >> 1) | ((op_v == 12) ? (c << 7) : 0);
                s = put_bit(s, 0, (av & 1) != 0); s = put_zn(s, r); end
            13: begin r = mv; s = put_zn(s, r); end
            default: ;
        endcase
        return {r[7:0], s[7:0]};
    endfunction

    function automatic string tag(int op_v);
        case (op_v)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 4, 5: return "R4";
            6: return "R5";
            7, 8: return "R6";
            9, 11: return "R7";
            10, 12: return "R8";
            13: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(int op_v, int av, int mv, int sv);
        logic [15:0] exp_v;
        @(posedge clk);
        #1;
        op = op_v[3:0]; a = av[7:0]; m = mv[7:0]; st_in = sv[7:0];
        exp_v = model(op_v, av, mv, sv);
        @(negedge clk);
        n_checks++;
        if ({res, st_out} !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h m=%02h st=%02h: got res=%02h st=%02h, expected res=%02h st=%02h",
                     tag(op_v), op_v, av, mv, sv, res, st_out, exp_v[15:8], exp_v[7:0]);
        end
        // R10: bits 2..5 pass straight through for every op
        n_checks++;
        if (st_out[5:2] !== st_in[5:2]) begin
            n_fail++;
            $display("FAIL R10 op=%0d: got sys bits %04b, expected %04b", op_v, st_out[5:2], st_in[5:2]);
        end
    endtask

    initial begin
        op = 4'd0; a = 8'd0; m = 8'd0; st_in = 8'd0;
        repeat (3) @(posedge clk);
        // R1: overflow without carry, carry with zero
        apply(0, 8'h50, 8'h50, 8'h00);
        apply(0, 8'hFF, 8'h01, 8'h00);
        apply(0, 8'h7F, 8'h00, 8'h01);
        // R10: decimal bit set gives the same binary sum
        apply(0, 8'h09, 8'h01, 8'h08);
        // R2: signed overflow, borrow to 0xFF
        apply(1, 8'h50, 8'hB0, 8'h01);
        apply(1, 8'h00, 8'h01, 8'h01);
        apply(1, 8'h05, 8'h05, 8'h00);
        // R3: equal, smaller, larger, with V preset
        apply(2, 8'h40, 8'h40, 8'h40);
        apply(2, 8'h10, 8'h20, 8'h41);
        apply(2, 8'hF0, 8'h01, 8'h40);
        // R4
        apply(3, 8'h0F, 8'hF0, 8'h41);
        apply(4, 8'h80, 8'h01, 8'h00);
        apply(5, 8'hAA, 8'hAA, 8'hC1);
        // R5: zero from the AND, sign bits from the operand
        apply(6, 8'h3F, 8'hC0, 8'h01);
        apply(6, 8'h01, 8'h01, 8'hC0);
        // R6: wrap both ways
        apply(7, 8'hFF, 8'h00, 8'h41);
        apply(8, 8'h00, 8'h00, 8'h41);
        // R7
        apply(9, 8'h80, 8'h00, 8'h01);
        apply(11, 8'h80, 8'h00, 8'h01);
        apply(11, 8'h40, 8'h00, 8'h00);
        // R8
        apply(10, 8'h01, 8'h00, 8'h01);
        apply(12, 8'h01, 8'h00, 8'h01);
        apply(12, 8'h80, 8'h00, 8'h00);
        // R9
        apply(13, 8'h12, 8'h80, 8'h00);
        apply(13, 8'h12, 8'h00, 8'h80);
        // R11
        apply(14, 8'h5A, 8'hA5, 8'hFF);
        apply(15, 8'h00, 8'hFF, 8'h3C);
        // every op with pseudo-random operands and status
        for (int i = 0; i < 1600; i++)
            apply(i % 16, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule